// File: doc/BRIEF.md
# Dual Step-Attenuator Control Selector

This block drives the 5-bit control words of two digital step attenuators. Each bit of a word switches in one binary-weighted attenuation stage, so a word encodes 0 to 31 dB in 1 dB steps. A single mode input picks where both words come from. In parallel mode each channel copies its own 5-bit input bus. In serial mode each channel reads one of four preset words, and two fast select pins per channel choose which one.

The presets are loaded through a serial shift register. It samples data on rising serial-clock edges while the active-low chip select is held low. It copies its preset fields into the active tables only when chip select rises. In serial mode each channel's parallel pins are turned around and echo the word now applied, with per-bit output enables. All serial-port inputs are sampled by the system clock and must be synchronous to it, each level held for at least one clock.

Top module: `step_atten_sel`

## Requirements
- R1: A control word is 5 bits. Bit k switches in the stage of weight 2^k dB (bit 0 = 1 dB, up to bit 4 = 16 dB). Channel c occupies bits [5c+4:5c] of every packed bus.
- R2: With `serial_mode`=0, each channel's `ctrl_word` equals that channel's `par_in` one clock earlier.
- R3: With `serial_mode`=1, channel c shows preset p = 2*`sel_b[c]` + `sel_a[c]`. Preset p of channel c sits in shift-register bits [8+28c+5p+4 : 8+28c+5p].
- R4: The shift register moves one place towards its MSB and takes `sdi` into bit 0 on each rising `sclk` while `cs_n`=0. While `cs_n`=1 it ignores `sclk`.
- R5: Presets change only on a rising edge of `cs_n`. Bits shifted in before that edge leave the applied words unchanged.
- R6: A frame cut short, with fewer than 56 bits, latches whatever the shift register holds when `cs_n` rises. The register is never cleared between frames.
- R7: In serial mode `par_oe` is all ones and `par_out` equals `ctrl_word`. In parallel mode `par_oe` and `par_out` are all zeros.
- R8: Synchronous reset clears every preset, `ctrl_word`, `par_out` and `par_oe` to 0.
- R9: The channels are independent. One channel's select pins and bus never change the other channel's word.
- R10: A change of select pins or parallel bus appears on `ctrl_word` after exactly one clock, with no serial access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 0: parallel buses, 1: preset tables |
| sclk | input | 1 | Serial clock (sampled by clk) |
| cs_n | input | 1 | Serial chip select, active low |
| sdi | input | 1 | Serial data, MSB first |
| sel_a | input | 2 | Preset select bit A, one per channel |
| sel_b | input | 2 | Preset select bit B, one per channel |
| par_in | input | 10 | Parallel control buses, channel-packed |
| par_out | output | 10 | Echo of the applied words in serial mode |
| par_oe | output | 10 | Per-pin output enables for the parallel buses |
| ctrl_word | output | 10 | Applied attenuator control words |

## Verification
The parallel path is swept through all 32 values on channel 0 while channel 1 carries the complement. Any bit swap, stuck bit or cross-channel mix-up therefore shows as a mismatch. After each random 56-bit frame, all 16 select combinations of the two channels are applied. This separates an A/B swap, a wrong field offset and a channel that follows its neighbour's pins. Further frames are placed to tell apart a latch at the frame end from a latch during shifting. These are a frame checked halfway through, clock pulses sent with chip select high, and a frame cut short at 13 bits.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int NPRE = 4;
  localparam int SELW = $clog2(NPRE);

  function automatic int field_lsb(input int base, input int stride, input int ch);
    return base + stride * ch;
  endfunction
endpackage

// File: rtl/sat_serial_rx.sv
module sat_serial_rx
  import sat_pkg::*;
#(
  parameter int FRAME  = 56,
  parameter int NCH    = 2,
  parameter int W      = 5,
  parameter int BASE   = 8,
  parameter int STRIDE = 28
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      sdi,
  output logic [NCH*W*NPRE-1:0]     fields,
  output logic                      load
);
  localparam int FIELD = W * NPRE;

  logic [FRAME-1:0] sr;
  logic             sclk_q;
  logic             cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      load   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      load   <= cs_n & ~cs_q;
      if (!cs_n && sclk && !sclk_q)
        sr <= {sr[FRAME-2:0], sdi};
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_field
    assign fields[c*FIELD +: FIELD] = sr[field_lsb(BASE, STRIDE, c) +: FIELD];
  end
endmodule

// File: rtl/sat_preset_bank.sv
module sat_preset_bank
  import sat_pkg::*;
#(
  parameter int W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [W*NPRE-1:0] field,
  input  logic [SELW-1:0]   sel,
  output logic [W-1:0]      word
);
  logic [W-1:0] tbl [NPRE];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPRE; p++) tbl[p] <= '0;
    end else if (load) begin
      for (int p = 0; p < NPRE; p++) tbl[p] <= field[p*W +: W];
    end
  end

  assign word = tbl[sel];
endmodule

// File: rtl/sat_chan_out.sv
module sat_chan_out #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serial_mode,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] preset_word,
  output logic [W-1:0] ctrl_word,
  output logic [W-1:0] par_out,
  output logic [W-1:0] par_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_word <= '0;
      par_out   <= '0;
      par_oe    <= '0;
    end else begin
      ctrl_word <= serial_mode ? preset_word : par_in;
      par_out   <= serial_mode ? preset_word : '0;
      par_oe    <= {W{serial_mode}};
    end
  end
endmodule

// File: rtl/step_atten_sel.sv
module step_atten_sel
  import sat_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int W      = 5,
  parameter int FRAME  = 56,
  parameter int BASE   = 8,
  parameter int STRIDE = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serial_mode,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [NCH-1:0]   sel_a,
  input  logic [NCH-1:0]   sel_b,
  input  logic [NCH*W-1:0] par_in,
  output logic [NCH*W-1:0] par_out,
  output logic [NCH*W-1:0] par_oe,
  output logic [NCH*W-1:0] ctrl_word
);
  localparam int FIELD = W * NPRE;

  logic [NCH*FIELD-1:0] fields;
  logic                 load;

  sat_serial_rx #(
    .FRAME(FRAME), .NCH(NCH), .W(W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .fields(fields), .load(load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] preset_word;

    sat_preset_bank #(.W(W)) u_bank (
      .clk(clk), .rst(rst), .load(load),
      .field(fields[c*FIELD +: FIELD]),
      .sel({sel_b[c], sel_a[c]}),
      .word(preset_word)
    );

    sat_chan_out #(.W(W)) u_out (
      .clk(clk), .rst(rst), .serial_mode(serial_mode),
      .par_in(par_in[c*W +: W]),
      .preset_word(preset_word),
      .ctrl_word(ctrl_word[c*W +: W]),
      .par_out(par_out[c*W +: W]),
      .par_oe(par_oe[c*W +: W])
    );
  end
endmodule

// File: rtl/step_atten_sel_chk.sv
module step_atten_sel_chk #(
  parameter int NCH   = 2,
  parameter int W     = 5,
  parameter int FIELD = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             serial_mode,
  input logic             cs_n,
  input logic [NCH*W-1:0] par_in,
  input logic [NCH*W-1:0] par_out,
  input logic [NCH*W-1:0] par_oe,
  input logic [NCH*W-1:0] ctrl_word,
  input logic [NCH*FIELD-1:0] fields,
  input logic             load
);
  // R8: reset leaves outputs cleared
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (ctrl_word == '0 && par_oe == '0 && par_out == '0));

  // R2: parallel mode copies the buses one clock later
  p_par_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> ctrl_word == $past(par_in));

  // R7: pin direction follows the mode
  p_oe_serial_r7: assert property (@(posedge clk) disable iff (rst)
    serial_mode |=> par_oe == '1);
  p_oe_parallel_r7: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> (par_oe == '0 && par_out == '0));
  p_echo_r7: assert property (@(posedge clk) disable iff (rst)
    (par_oe == '1) |-> par_out == ctrl_word);

  // R4: no shifting while chip select is high
  p_shift_hold_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(fields));

  // R5: a preset load only follows a rising chip select
  p_load_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind step_atten_sel step_atten_sel_chk #(
  .NCH(NCH), .W(W), .FIELD(FIELD)
) u_chk (
  .clk(clk), .rst(rst), .serial_mode(serial_mode), .cs_n(cs_n),
  .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
  .ctrl_word(ctrl_word), .fields(fields), .load(load)
);

// File: tb/step_atten_sel_tb.sv
`timescale 1ns/1ps
module step_atten_sel_tb;
  localparam int NCH = 2;
  localparam int W   = 5;

  logic clk = 1'b0;
  logic rst, serial_mode, sclk, cs_n, sdi;
  logic [NCH-1:0]   sel_a, sel_b;
  logic [NCH*W-1:0] par_in, par_out, par_oe, ctrl_word;

  logic [55:0] m_sr, m_tbl;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  step_atten_sel u_dut (
    .clk(clk), .rst(rst), .serial_mode(serial_mode), .sclk(sclk),
    .cs_n(cs_n), .sdi(sdi), .sel_a(sel_a), .sel_b(sel_b),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .ctrl_word(ctrl_word)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; sclk = 1'b1; step();
    sclk = 1'b0; step();
    m_sr = {m_sr[54:0], b};
  endtask

  task automatic cs_rise();
    cs_n = 1'b1; step(); step(); step();
    m_tbl = m_sr;
  endtask

  function automatic logic [4:0] exp_word(input int ch, input int s);
    return m_tbl[8 + 28*ch + 5*s +: 5];
  endfunction

  task automatic sweep_sel(input string tag);
    for (int s0 = 0; s0 < 4; s0++) begin
      for (int s1 = 0; s1 < 4; s1++) begin
        sel_a = {s1[0], s0[0]};
        sel_b = {s1[1], s0[1]};
        step();
        chk({tag, " R3 R9 R10 ch0"}, 32'(ctrl_word[4:0]), 32'(exp_word(0, s0)));
        chk({tag, " R3 R9 R10 ch1"}, 32'(ctrl_word[9:5]), 32'(exp_word(1, s1)));
        chk({tag, " R7 echo"}, 32'(par_out), 32'(ctrl_word));
        chk({tag, " R7 oe"}, 32'(par_oe), 32'h3FF);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    rst = 1'b1; serial_mode = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    sel_a = '0; sel_b = '0; par_in = '0;
    m_sr = '0; m_tbl = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    chk("R8 ctrl after reset", 32'(ctrl_word), 0);
    chk("R8 oe after reset", 32'(par_oe), 0);
    serial_mode = 1'b1; sel_a = 2'b11; sel_b = 2'b01; step();
    chk("R8 presets cleared", 32'(ctrl_word), 0);
    chk("R7 oe in serial", 32'(par_oe), 32'h3FF);

    // parallel sweep, channel 1 carries the complement
    serial_mode = 1'b0;
    for (int v = 0; v < 32; v++) begin
      par_in = {5'(31 - v), 5'(v)};
      step();
      chk("R1 R2 R10 parallel", 32'(ctrl_word), 32'({5'(31 - v), 5'(v)}));
      chk("R7 parallel pins", 32'({par_oe, par_out}), 0);
    end

    // full random frame
    serial_mode = 1'b1;
    r = {$urandom(), $urandom()};
    cs_n = 1'b0; step();
    for (int i = 55; i >= 0; i--) shift_bit(r[i]);
    cs_rise();
    sweep_sel("frame1");

    // second frame, checked halfway through
    sel_a = 2'b10; sel_b = 2'b01; step();
    r = {$urandom(), $urandom()};
    cs_n = 1'b0; step();
    for (int i = 55; i >= 26; i--) shift_bit(r[i]);
    chk("R5 mid-frame ch0", 32'(ctrl_word[4:0]), 32'(exp_word(0, 2)));
    chk("R5 mid-frame ch1", 32'(ctrl_word[9:5]), 32'(exp_word(1, 1)));
    for (int i = 25; i >= 0; i--) shift_bit(r[i]);
    cs_rise();
    sweep_sel("frame2");

    // clock pulses with chip select high are ignored
    for (int i = 0; i < 10; i++) begin
      sdi = 1'($urandom()); sclk = 1'b1; step(); sclk = 1'b0; step();
    end
    cs_n = 1'b0; step();
    cs_rise();
    sweep_sel("R4 cs high");

    // aborted frame of 13 bits
    r = {$urandom(), $urandom()};
    cs_n = 1'b0; step();
    for (int i = 12; i >= 0; i--) shift_bit(r[i]);
    cs_rise();
    sweep_sel("R6 aborted");

    // back to parallel
    serial_mode = 1'b0; par_in = 10'h2A5; step();
    chk("R2 mode back", 32'(ctrl_word), 32'h2A5);
    chk("R7 oe off", 32'(par_oe), 0);
    chk("R7 out off", 32'(par_out), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule